// File: doc/BRIEF.md
# Display Clock Frequency Change Sequencer

This block moves a display core clock from whatever rate it runs at to a requested target rate. A request carries the target in kHz and a one-cycle start strobe. The block checks that the target is one it can make. It then tells an external power controller that a change is about to happen and reads the present rate back from the clock control register. If the transition needs it, the block takes the display PLL down. It then programs the PLL ratio, brings the PLL up and waits for lock. It rewrites the divider, precharge and rate fields of the clock control register. Last, it reports the new rate to the power controller.

Register accesses go out one at a time over a valid/ready port that selects one of three registers. The power controller is reached through a request/acknowledge mailbox whose acknowledge carries a failure flag. When the sequence ends, the block raises a one-cycle done pulse. An error flag rides on that pulse.

Top module: `dclk_seq`

## Requirements
- R1: The only accepted targets are 19200 (bypass), 144000, 288000, 384000, 576000 and 624000 kHz. Any other target ends with done and error set, and with no register access and no mailbox request.
- R2: The first action of every accepted request is a mailbox request with command 0x17 and data 0x80000000. If its acknowledge reports failure, the request ends with done and error set and no register access.
- R3: Register select is 0 for the PLL control register, 1 for the PLL enable register and 2 for the clock control register. The present rate is read from clock control bits [10:0] as kHz = field*500+1000. The PLL is switched off only when the target is bypass, when the target is 624000, or when the present rate is 624000. Switching off means writing 0 to the PLL enable register and then polling it until lock (bit 30) reads 0.
- R4: For every non-bypass target, three writes follow in this order. First, the PLL control register is written with bits [7:0] set to the ratio (60, or 65 for 624000) and the other bits kept. Second, the PLL enable register is written with 0x80000000 (enable is bit 31), and it is then polled until lock reads 1. Third, the clock control register is written.
- R5: The clock control write keeps every bit it does not own. It sets bits [23:22] to the divider code (0 = /1 for 576000 and 624000, 1 = /1.5 for 384000, 2 = /2 for 288000, 3 = /4 for 144000). It sets bit 16 exactly when the target is at least 500000. It sets bits [10:0] to (kHz-1000)/500 rounded down.
- R6: The final action is a mailbox request with command 0x17 and data ceil(kHz/25000). If its acknowledge reports failure, error is set.
- R7: A lock or unlock poll that has not succeeded within the timeout window sets error and lets the sequence go on.
- R8: A request made while a sequence is in progress is ignored. Done pulses for exactly one cycle per accepted request.
- R9: A register access holds select, direction and write data stable until ready. A mailbox request holds its command and data stable until acknowledge. The two are never active together.
- R10: After reset, no register access, no mailbox request and no done pulse is active.
- R11: A bypass target writes nothing except the PLL enable register, and only with its enable bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Start strobe for a rate change |
| req_khz_i | input | 20 | Target rate in kHz |
| done_o | output | 1 | One-cycle pulse at the end of a request |
| err_o | output | 1 | Error flag, valid while done_o is high |
| bus_valid_o | output | 1 | Register access pending |
| bus_write_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 2 | Register select (0 PLL control, 1 PLL enable, 2 clock control) |
| bus_wdata_o | output | 32 | Write data |
| bus_ready_i | input | 1 | Access accepted; read data valid this cycle |
| bus_rdata_i | input | 32 | Read data |
| mb_req_o | output | 1 | Mailbox request pending |
| mb_cmd_o | output | 8 | Mailbox command |
| mb_data_o | output | 32 | Mailbox data |
| mb_ack_i | input | 1 | Mailbox acknowledge |
| mb_fail_i | input | 1 | Failure flag, valid with mb_ack_i |

## Verification
The assertions assume that the register port and the mailbox each answer a pending request within a bounded time. They also assume that ready and acknowledge arrive only while the matching request is high, so that read data and the failure flag are meaningful only in that cycle. The bench models the register file, the PLL lock delay and the power controller as responders. Each responder raises ready or acknowledge for exactly one cycle, one cycle after it sees a request. Lock is stuck at 0 or at 1 only when a test deliberately exercises the timeout path.

// File: rtl/dclk_pkg.sv
package dclk_pkg;
  localparam int KHZ_W   = 20;
  localparam int DATA_W  = 32;
  localparam int FLD_W   = 11;
  localparam int RATIO_W = 8;
  localparam int LOCK_BIT = 30;
  localparam int EN_BIT   = 31;
  localparam int PRE_BIT  = 16;
  localparam int DIV_LSB  = 22;
  localparam int PRE_MIN_KHZ = 500000;
  localparam int TOP_KHZ     = 624000;
  localparam logic [7:0]  PCU_FREQ_CMD = 8'h17;
  localparam logic [31:0] PCU_NOTIFY   = 32'h8000_0000;

  typedef enum logic [1:0] {
    REG_PLL_CTL = 2'd0,
    REG_PLL_EN  = 2'd1,
    REG_CLK_CTL = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic              ok;
    logic              bypass;
    logic              top;
    logic [RATIO_W-1:0] ratio;
    logic [1:0]        div;
    logic              pre;
    logic [FLD_W-1:0]  fld;
    logic [7:0]        pcu_code;
    logic [KHZ_W-1:0]  khz;
  } tgt_cfg_t;

  typedef enum logic [3:0] {
    S_IDLE, S_NOTIFY, S_RD_CUR, S_DIS_WR, S_DIS_POLL, S_RAT_RD, S_RAT_WR,
    S_EN_WR, S_EN_POLL, S_CLK_RD, S_CLK_WR, S_COMMIT, S_DONE
  } seq_state_e;
endpackage

// File: rtl/dclk_target_dec.sv
module dclk_target_dec
  import dclk_pkg::*;
(
  input  logic [KHZ_W-1:0] khz_i,
  output tgt_cfg_t         cfg_o
);
  function automatic tgt_cfg_t mk(input int khz, input int ratio, input logic [1:0] div);
    tgt_cfg_t c;
    c.ok       = 1'b1;
    c.bypass   = (ratio == 0);
    c.top      = (khz == TOP_KHZ);
    c.ratio    = RATIO_W'(ratio);
    c.div      = div;
    c.pre      = (khz >= PRE_MIN_KHZ);
    c.fld      = FLD_W'((khz - 1000) / 500);
    c.pcu_code = 8'((khz + 24999) / 25000);
    c.khz      = KHZ_W'(khz);
    return c;
  endfunction

  always_comb begin
    case (khz_i)
      20'd19200:  cfg_o = mk(19200,  0,  2'd0);
      20'd144000: cfg_o = mk(144000, 60, 2'd3);
      20'd288000: cfg_o = mk(288000, 60, 2'd2);
      20'd384000: cfg_o = mk(384000, 60, 2'd1);
      20'd576000: cfg_o = mk(576000, 60, 2'd0);
      20'd624000: cfg_o = mk(624000, 65, 2'd0);
      default:    cfg_o = '0;
    endcase
  end
endmodule

// File: rtl/dclk_wait_timer.sv
module dclk_wait_timer #(
  parameter int LIMIT = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  logic [CNT_W-1:0] cnt_q;

  assign expired_o = (cnt_q == CNT_W'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end

  // R7: counter restarts whenever no poll is in progress
  assert_timer_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/dclk_rmw.sv
module dclk_rmw
  import dclk_pkg::*;
(
  input  tgt_cfg_t          cfg_i,
  input  logic [DATA_W-1:0] rd_i,
  output logic [DATA_W-1:0] ratio_wd_o,
  output logic [DATA_W-1:0] clk_wd_o
);
  localparam logic [DATA_W-1:0] RATIO_MASK = DATA_W'((1 << RATIO_W) - 1);
  localparam logic [DATA_W-1:0] FLD_MASK   = DATA_W'((1 << FLD_W) - 1);
  localparam logic [DATA_W-1:0] DIV_MASK   = DATA_W'(3) << DIV_LSB;
  localparam logic [DATA_W-1:0] PRE_MASK   = DATA_W'(1) << PRE_BIT;

  assign ratio_wd_o = (rd_i & ~RATIO_MASK) | DATA_W'(cfg_i.ratio);

  always_comb begin
    clk_wd_o = rd_i & ~(FLD_MASK | DIV_MASK | PRE_MASK);
    clk_wd_o |= DATA_W'(cfg_i.div) << DIV_LSB;
    clk_wd_o |= DATA_W'(cfg_i.pre) << PRE_BIT;
    clk_wd_o |= DATA_W'(cfg_i.fld);
  end
endmodule

// File: rtl/dclk_seq.sv
module dclk_seq
  import dclk_pkg::*;
#(
  parameter int CLK_KHZ = 100000,
  parameter int WAIT_US = 1000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [19:0] req_khz_i,
  output logic        done_o,
  output logic        err_o,
  output logic        bus_valid_o,
  output logic        bus_write_o,
  output logic [1:0]  bus_addr_o,
  output logic [31:0] bus_wdata_o,
  input  logic        bus_ready_i,
  input  logic [31:0] bus_rdata_i,
  output logic        mb_req_o,
  output logic [7:0]  mb_cmd_o,
  output logic [31:0] mb_data_o,
  input  logic        mb_ack_i,
  input  logic        mb_fail_i
);
  localparam int WAIT_CYC = (CLK_KHZ / 1000) * WAIT_US;

  seq_state_e        state_q;
  tgt_cfg_t          dec_cfg, cfg_q;
  logic [DATA_W-1:0] rd_q, ratio_wd, clk_wd;
  logic              err_q, polling, tmo, acc, mb_done;
  logic [20:0]       cur_khz;

  dclk_target_dec u_dec (.khz_i(req_khz_i), .cfg_o(dec_cfg));
  dclk_rmw u_rmw (.cfg_i(cfg_q), .rd_i(rd_q), .ratio_wd_o(ratio_wd), .clk_wd_o(clk_wd));
  dclk_wait_timer #(.LIMIT(WAIT_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(polling), .expired_o(tmo));

  assign polling = (state_q == S_DIS_POLL) || (state_q == S_EN_POLL);
  assign acc     = bus_valid_o && bus_ready_i;
  assign mb_done = mb_req_o && mb_ack_i;
  assign cur_khz = 21'(bus_rdata_i[FLD_W-1:0]) * 21'd500 + 21'd1000;

  // register port drive
  always_comb begin
    bus_valid_o = 1'b1;
    bus_write_o = 1'b0;
    bus_addr_o  = REG_PLL_EN;
    bus_wdata_o = '0;
    case (state_q)
      S_RD_CUR:   bus_addr_o = REG_CLK_CTL;
      S_DIS_WR:   bus_write_o = 1'b1;
      S_DIS_POLL: ;
      S_RAT_RD:   bus_addr_o = REG_PLL_CTL;
      S_RAT_WR:   begin bus_addr_o = REG_PLL_CTL; bus_write_o = 1'b1; bus_wdata_o = ratio_wd; end
      S_EN_WR:    begin bus_write_o = 1'b1; bus_wdata_o = DATA_W'(1) << EN_BIT; end
      S_EN_POLL:  ;
      S_CLK_RD:   bus_addr_o = REG_CLK_CTL;
      S_CLK_WR:   begin bus_addr_o = REG_CLK_CTL; bus_write_o = 1'b1; bus_wdata_o = clk_wd; end
      default:    bus_valid_o = 1'b0;
    endcase
  end

  // power controller mailbox drive
  assign mb_req_o  = (state_q == S_NOTIFY) || (state_q == S_COMMIT);
  assign mb_cmd_o  = mb_req_o ? PCU_FREQ_CMD : 8'h00;
  assign mb_data_o = (state_q == S_NOTIFY) ? PCU_NOTIFY :
                     (state_q == S_COMMIT) ? DATA_W'(cfg_q.pcu_code) : '0;

  assign done_o = (state_q == S_DONE);
  assign err_o  = done_o && err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cfg_q   <= '0;
      rd_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      if (acc && !bus_write_o) rd_q <= bus_rdata_i;
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          cfg_q   <= dec_cfg;
          err_q   <= !dec_cfg.ok;
          state_q <= dec_cfg.ok ? S_NOTIFY : S_DONE;
        end
        S_NOTIFY: if (mb_done) begin
          err_q   <= mb_fail_i;
          state_q <= mb_fail_i ? S_DONE : S_RD_CUR;
        end
        S_RD_CUR: if (acc)
          state_q <= (cfg_q.bypass || cfg_q.top || cur_khz == 21'(TOP_KHZ)) ? S_DIS_WR : S_RAT_RD;
        S_DIS_WR: if (acc) state_q <= S_DIS_POLL;
        S_DIS_POLL: if (acc && (!bus_rdata_i[LOCK_BIT] || tmo)) begin
          if (bus_rdata_i[LOCK_BIT]) err_q <= 1'b1;
          state_q <= cfg_q.bypass ? S_COMMIT : S_RAT_RD;
        end
        S_RAT_RD: if (acc) state_q <= S_RAT_WR;
        S_RAT_WR: if (acc) state_q <= S_EN_WR;
        S_EN_WR:  if (acc) state_q <= S_EN_POLL;
        S_EN_POLL: if (acc && (bus_rdata_i[LOCK_BIT] || tmo)) begin
          if (!bus_rdata_i[LOCK_BIT]) err_q <= 1'b1;
          state_q <= S_CLK_RD;
        end
        S_CLK_RD: if (acc) state_q <= S_CLK_WR;
        S_CLK_WR: if (acc) state_q <= S_COMMIT;
        S_COMMIT: if (mb_done) begin
          if (mb_fail_i) err_q <= 1'b1;
          state_q <= S_DONE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_bus_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_addr_o)
      && $stable(bus_write_o) && $stable(bus_wdata_o));
  assert_mb_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_req_o && !mb_ack_i |=> mb_req_o && $stable(mb_cmd_o) && $stable(mb_data_o));
  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_valid_o && mb_req_o));
  assert_bad_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_IDLE && req_valid_i && !dec_cfg.ok |=> done_o && err_o && !bus_valid_o && !mb_req_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_bypass_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_write_o && cfg_q.bypass |-> bus_addr_o == REG_PLL_EN && !bus_wdata_o[EN_BIT]);
  assert_precharge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_write_o && bus_addr_o == REG_CLK_CTL
      |-> bus_wdata_o[PRE_BIT] == (cfg_q.khz >= KHZ_W'(PRE_MIN_KHZ)));
endmodule

// File: tb/dclk_seq_test.sv
module dclk_seq_test;
  typedef struct {
    logic [41:0] v;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_khz = '0;
  logic        done, err;
  logic        bus_valid, bus_write;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ready = 1'b0;
  logic        mb_req, mb_fail;
  logic [7:0]  mb_cmd;
  logic [31:0] mb_data;
  logic        mb_ack = 1'b0;

  int compared = 0, mismatched = 0;
  exp_t q[$];

  // external models
  logic [31:0] pll_ctl_m = 32'hA5A5_5A00;
  logic [31:0] clk_ctl_m = 32'hF0C1_0000 | 32'd36;
  logic        en_m = 1'b0, lock_m = 1'b0;
  int          lock_cnt = 0;
  int          stuck = 0;
  bit          fail_n = 0, fail_c = 0;

  always #5 clk = ~clk;

  dclk_seq #(.CLK_KHZ(100000), .WAIT_US(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_khz_i(req_khz),
    .done_o(done), .err_o(err), .bus_valid_o(bus_valid), .bus_write_o(bus_write),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_ready_i(bus_ready),
    .bus_rdata_i(bus_rdata), .mb_req_o(mb_req), .mb_cmd_o(mb_cmd), .mb_data_o(mb_data),
    .mb_ack_i(mb_ack), .mb_fail_i(mb_fail));

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = pll_ctl_m;
      2'd1:    bus_rdata = {en_m, lock_m, 30'b0};
      2'd2:    bus_rdata = clk_ctl_m;
      default: bus_rdata = '0;
    endcase
  end
  assign mb_fail = mb_ack && ((mb_data == 32'h8000_0000) ? fail_n : fail_c);

  always @(posedge clk) begin
    bus_ready <= bus_valid && !bus_ready;
    mb_ack    <= mb_req && !mb_ack;
    if (bus_valid && bus_ready && bus_write)
      case (bus_addr)
        2'd0: pll_ctl_m <= bus_wdata;
        2'd1: en_m      <= bus_wdata[31];
        2'd2: clk_ctl_m <= bus_wdata;
        default: ;
      endcase
    if (stuck == 1)      begin lock_m <= 1'b0; lock_cnt <= 0; end
    else if (stuck == 2) begin lock_m <= 1'b1; lock_cnt <= 0; end
    else if (en_m != lock_m) begin
      if (lock_cnt == 25) begin lock_m <= en_m; lock_cnt <= 0; end
      else lock_cnt <= lock_cnt + 1;
    end else lock_cnt <= 0;
  end

  // monitor: compare observed actions with the scoreboard queue
  task automatic observe(logic [41:0] act);
    exp_t e;
    compared++;
    if (q.size() == 0) begin
      mismatched++;
      $display("FAIL unexpected action: actual %h expected none", act);
    end else begin
      e = q.pop_front();
      if (e.v !== act) begin
        mismatched++;
        $display("FAIL %s: actual %h expected %h", e.tag, act, e.v);
      end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (bus_valid && bus_ready && bus_write) observe({2'd0, 6'(bus_addr), bus_wdata});
    if (mb_req && mb_ack)                    observe({2'd1, mb_cmd, mb_data});
    if (done)                                observe({2'd2, 8'd0, 31'd0, err});
  end

  task automatic push(logic [1:0] k, logic [7:0] a, logic [31:0] d, string t);
    exp_t e;
    e.v = {k, a, d};
    e.tag = t;
    q.push_back(e);
  endtask

  task automatic check(bit ok, string t, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  // driver: derive the expected actions from the requirements, then start
  task automatic run(int khz, int intrude_khz);
    bit valid, byp, off, e;
    int div, ratio, fld;
    logic [31:0] cw;
    valid = (khz == 19200 || khz == 144000 || khz == 288000 || khz == 384000 ||
             khz == 576000 || khz == 624000);
    byp = (khz == 19200);
    e = 0;
    if (!valid) push(2'd2, 8'd0, 32'd1, "R1 invalid target");
    else begin
      push(2'd1, 8'h17, 32'h8000_0000, "R2 notify");
      if (fail_n) push(2'd2, 8'd0, 32'd1, "R2 notify failure");
      else begin
        off = byp || khz == 624000 || (int'(clk_ctl_m[10:0]) * 500 + 1000) == 624000;
        if (off) begin
          push(2'd0, 8'd1, 32'h0, "R3 pll disable");
          if (stuck == 2) e = 1;
        end
        if (!byp) begin
          ratio = (khz == 624000) ? 65 : 60;
          case (khz)
            144000:  div = 3;
            288000:  div = 2;
            384000:  div = 1;
            default: div = 0;
          endcase
          fld = (khz - 1000) / 500;
          push(2'd0, 8'd0, (pll_ctl_m & ~32'hFF) | 32'(ratio), "R4 ratio write");
          push(2'd0, 8'd1, 32'h8000_0000, "R4 pll enable");
          if (stuck == 1) e = 1;
          cw = clk_ctl_m & ~(32'h3 << 22) & ~(32'h1 << 16) & ~32'h7FF;
          cw |= (32'(div) << 22) | (32'(khz >= 500000) << 16) | 32'(fld);
          push(2'd0, 8'd2, cw, "R5 clock control write");
        end
        push(2'd1, 8'h17, 32'((khz + 24999) / 25000), "R6 commit");
        if (fail_c || e) push(2'd2, 8'd0, 32'd1, "R6/R7 done with error");
        else push(2'd2, 8'd0, 32'd0, "R6 done ok");
      end
    end
    @(negedge clk);
    req_valid = 1'b1;
    req_khz = 20'(khz);
    @(negedge clk);
    req_valid = 1'b0;
    if (intrude_khz != 0) begin
      repeat (6) @(negedge clk);
      req_valid = 1'b1;
      req_khz = 20'(intrude_khz);
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R8 all expected actions seen", 32'(q.size()), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    check(!bus_valid && !mb_req && !done, "R10 reset idle",
          {29'd0, bus_valid, mb_req, done}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!bus_valid && !mb_req && !done, "R10 after reset release",
          {29'd0, bus_valid, mb_req, done}, 32'd0);

    run(624000, 0);   // R3 R4 R5: to top rate, PLL toggled
    run(288000, 0);   // R3: away from top rate, PLL toggled
    run(384000, 0);   // R3: no disable
    run(576000, 0);   // R5: precharge set
    run(144000, 0);   // R5: divide by 4
    run(19200, 0);    // R11: bypass
    snap = clk_ctl_m;
    run(100000, 0);   // R1
    check(clk_ctl_m == snap, "R1 clock control untouched", clk_ctl_m, snap);
    fail_n = 1;
    run(288000, 0);   // R2 notify failure
    fail_n = 0;
    check(clk_ctl_m == snap, "R2 no writes after failed notify", clk_ctl_m, snap);
    fail_c = 1;
    run(576000, 0);   // R6 commit failure
    fail_c = 0;
    stuck = 1;
    run(384000, 0);   // R7 lock never rises
    stuck = 2;
    run(19200, 0);    // R7 lock never falls
    stuck = 0;
    run(624000, 144000);  // R8 request while busy ignored
    check(clk_ctl_m[10:0] == 11'd1246, "R8 busy request left no trace",
          32'(clk_ctl_m[10:0]), 32'd1246);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule